// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits behind the host-side bus of a 16-bit NOR flash and turns the stream of latched bus write events into an operating mode and operation requests. Each write event carries a 20-bit address and a 16-bit data word, and the command code is the low byte of the data. The decoder tracks multi-cycle command sequences (block erase, word program, double-word program). It sends one-cycle start requests, with the latched address and data, to the program/erase controller. It also produces one-cycle clear-status, suspend and resume pulses, and a one-cycle erase-confirm failure pulse that the status logic uses to set its erase and program error bits.

What the decoder accepts depends on the controller. While the controller reports busy, only the read-status and suspend codes are taken. While an operation is suspended, a restricted set of codes is accepted. Program is added to that set only when the suspended operation is an erase. The decoder also returns the identification code for signature reads, selected by address bit 0 of the read address.

The sequence state machine has five states. READY waits for a command. ERS_CONFIRM waits for the erase confirm. PRG_WORD waits for the program address and data. DW_FIRST waits for the first word of a pair, and DW_SECOND waits for the second word. The transitions are as follows:
- READY to ERS_CONFIRM on 20h, to PRG_WORD on 40h or 10h, and to DW_FIRST on 30h.
- ERS_CONFIRM to READY on any write, starting the erase on D0h and failing otherwise.
- PRG_WORD to READY on the data write, starting the program.
- DW_FIRST to DW_SECOND on the first word.
- DW_SECOND to READY on the second word, starting the pair if the addresses are valid and otherwise abandoning it.
- READY to PRG_WORD while an erase is suspended and 40h or 10h is written.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read mode is array (0), no request or pulse output is high, and the sequence state is READY.
- R2: In READY, with no operation running or suspended, a write sets the read mode from the low data byte. FFh selects array (0), 70h selects status (1), 90h selects signature (2) and 98h selects CFI (3). The mode output is 2 bits with those encodings.
- R3: In READY, with no operation running or suspended, a write of 50h pulses clear_pulse for one cycle and leaves the read mode unchanged.
- R4: A write of 20h followed by a write of D0h pulses erase_req for one cycle, with op_addr holding the address of the D0h write, and sets status mode. Each write event yields at most one request or pulse.
- R5: A write of 20h followed by any low byte other than D0h pulses erase_fail for one cycle, starts no erase and sets array mode.
- R6: A write of 40h or 10h followed by one more write pulses prog_req for one cycle, with op_addr and op_data holding that write's address and data, and sets status mode.
- R7: The sequence 30h, word 1, word 2 pulses dw_req with op_addr and op_data set to word 1 and op_addr2 and op_data2 set to word 2, and sets status mode. This happens only if the two addresses are equal in bits 19:1 and differ in bit 0. Otherwise nothing starts and the mode becomes array.
- R8: While busy is high, read_mode reads status (1). A 70h write sets status mode and a B0h write pulses suspend_pulse. Every other write is ignored, including the setup codes of multi-cycle commands.
- R9: While ers_susp or prg_susp is high, the decoder accepts these writes:
  - D0h pulses resume_pulse and sets status mode.
  - FFh, 70h, 90h and 98h set the mode as in R2.
  - 40h or 10h starts a program sequence, but only when ers_susp is high.
  
  Every other write is ignored.
- R10: In READY, with no operation running or suspended, any low byte that is not a command code, as well as B0h or D0h, sets array mode and produces no pulse.
- R11: sig_data is registered from rd_addr each cycle. It is 0020h when bit 0 is low. When bit 0 is high it is 0090h if TOP_BOOT is 1 and 0091h if TOP_BOOT is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; returns the decoder to READY and array mode |
| wr_stb | input | 1 | One-cycle strobe marking a latched bus write |
| wr_addr | input | 20 | Address of the latched write |
| wr_data | input | 16 | Data of the latched write; command code in bits 7:0 |
| rd_addr | input | 20 | Current read address, bit 0 selects the signature code |
| busy | input | 1 | Program/erase controller running |
| ers_susp | input | 1 | An erase is suspended |
| prg_susp | input | 1 | A program is suspended |
| read_mode | output | 2 | 0 array, 1 status, 2 signature, 3 CFI |
| erase_req | output | 1 | Start block erase |
| prog_req | output | 1 | Start word program |
| dw_req | output | 1 | Start double-word program |
| erase_fail | output | 1 | Erase confirm was wrong; set erase and program error bits |
| clear_pulse | output | 1 | Clear status error bits |
| suspend_pulse | output | 1 | Suspend the running operation |
| resume_pulse | output | 1 | Resume the suspended operation |
| op_addr | output | 20 | Address for erase, program or first word |
| op_data | output | 16 | Data for program or first word |
| op_addr2 | output | 20 | Address of the second word |
| op_data2 | output | 16 | Data of the second word |
| sig_data | output | 16 | Signature read data |

## Verification
The bench first checks each single-cycle code with the controller idle. It then replays the same codes with the controller busy, with an erase suspended and with a program suspended, so that each accepted code is told apart from an ignored one in each controller context. The multi-cycle sequences are run with a correct confirm and with a wrong confirm, and with an adjacent address pair and with a pair that differs above bit 0. These runs tell a started operation from an abandoned one. Signature reads are taken with address bit 0 low and high.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_SIG    = 2'd2,
        RM_CFI    = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        ST_READY       = 3'd0,
        ST_ERS_CONFIRM = 3'd1,
        ST_PRG_WORD    = 3'd2,
        ST_DW_FIRST    = 3'd3,
        ST_DW_SECOND   = 3'd4
    } seq_state_e;

    localparam logic [7:0] OPC_READ_ARRAY = 8'hFF;
    localparam logic [7:0] OPC_READ_STAT  = 8'h70;
    localparam logic [7:0] OPC_READ_SIG   = 8'h90;
    localparam logic [7:0] OPC_READ_CFI   = 8'h98;
    localparam logic [7:0] OPC_CLEAR      = 8'h50;
    localparam logic [7:0] OPC_SUSPEND    = 8'hB0;
    localparam logic [7:0] OPC_CONFIRM    = 8'hD0;
    localparam logic [7:0] OPC_ERASE      = 8'h20;
    localparam logic [7:0] OPC_PROG_A     = 8'h40;
    localparam logic [7:0] OPC_PROG_B     = 8'h10;
    localparam logic [7:0] OPC_DWPROG     = 8'h30;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          busy,
    input  logic          ers_susp,
    input  logic          prg_susp,
    output rd_mode_e      mode_q,
    output logic          erase_req,
    output logic          prog_req,
    output logic          dw_req,
    output logic          erase_fail,
    output logic          clear_pulse,
    output logic          suspend_pulse,
    output logic          resume_pulse,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic [AW-1:0] op_addr2,
    output logic [DW-1:0] op_data2
);

    localparam int OPW = 8;

    seq_state_e    state_q, state_d;
    rd_mode_e      mode_d;
    logic [OPW-1:0] opc;
    logic          any_susp;
    logic          pair_ok;
    logic          ers_d, prg_d, dw_d, fail_d, clr_d, sus_d, res_d;
    logic [AW-1:0] addr_d, addr2_d;
    logic [DW-1:0] data_d, data2_d;

    assign opc      = wr_data[OPW-1:0];
    assign any_susp = ers_susp | prg_susp;
    assign pair_ok  = (wr_addr[AW-1:1] == op_addr[AW-1:1]) && (wr_addr[0] != op_addr[0]);

    // Next-state and next-output decode
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        ers_d   = 1'b0;
        prg_d   = 1'b0;
        dw_d    = 1'b0;
        fail_d  = 1'b0;
        clr_d   = 1'b0;
        sus_d   = 1'b0;
        res_d   = 1'b0;
        addr_d  = op_addr;
        data_d  = op_data;
        addr2_d = op_addr2;
        data2_d = op_data2;
        if (wr_stb) begin
            unique case (state_q)
                ST_READY: begin
                    if (busy) begin
                        if (opc == OPC_READ_STAT)     mode_d = RM_STATUS;
                        else if (opc == OPC_SUSPEND)  sus_d  = 1'b1;
                    end else if (any_susp) begin
                        case (opc)
                            OPC_CONFIRM: begin
                                res_d  = 1'b1;
                                mode_d = RM_STATUS;
                            end
                            OPC_READ_ARRAY: mode_d = RM_ARRAY;
                            OPC_READ_STAT:  mode_d = RM_STATUS;
                            OPC_READ_SIG:   mode_d = RM_SIG;
                            OPC_READ_CFI:   mode_d = RM_CFI;
                            OPC_PROG_A, OPC_PROG_B: begin
                                if (ers_susp) state_d = ST_PRG_WORD;
                            end
                            default: ;
                        endcase
                    end else begin
                        case (opc)
                            OPC_READ_ARRAY: mode_d  = RM_ARRAY;
                            OPC_READ_STAT:  mode_d  = RM_STATUS;
                            OPC_READ_SIG:   mode_d  = RM_SIG;
                            OPC_READ_CFI:   mode_d  = RM_CFI;
                            OPC_CLEAR:      clr_d   = 1'b1;
                            OPC_ERASE:      state_d = ST_ERS_CONFIRM;
                            OPC_PROG_A, OPC_PROG_B: state_d = ST_PRG_WORD;
                            OPC_DWPROG:     state_d = ST_DW_FIRST;
                            default:        mode_d  = RM_ARRAY;
                        endcase
                    end
                end
                ST_ERS_CONFIRM: begin
                    state_d = ST_READY;
                    if (opc == OPC_CONFIRM) begin
                        ers_d  = 1'b1;
                        addr_d = wr_addr;
                        mode_d = RM_STATUS;
                    end else begin
                        fail_d = 1'b1;
                        mode_d = RM_ARRAY;
                    end
                end
                ST_PRG_WORD: begin
                    state_d = ST_READY;
                    prg_d   = 1'b1;
                    addr_d  = wr_addr;
                    data_d  = wr_data;
                    mode_d  = RM_STATUS;
                end
                ST_DW_FIRST: begin
                    state_d = ST_DW_SECOND;
                    addr_d  = wr_addr;
                    data_d  = wr_data;
                end
                ST_DW_SECOND: begin
                    state_d = ST_READY;
                    if (pair_ok) begin
                        dw_d    = 1'b1;
                        addr2_d = wr_addr;
                        data2_d = wr_data;
                        mode_d  = RM_STATUS;
                    end else begin
                        mode_d  = RM_ARRAY;
                    end
                end
                default: state_d = ST_READY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q        <= RM_ARRAY;
            erase_req     <= 1'b0;
            prog_req      <= 1'b0;
            dw_req        <= 1'b0;
            erase_fail    <= 1'b0;
            clear_pulse   <= 1'b0;
            suspend_pulse <= 1'b0;
            resume_pulse  <= 1'b0;
            op_addr       <= '0;
            op_data       <= '0;
            op_addr2      <= '0;
            op_data2      <= '0;
        end else begin
            mode_q        <= mode_d;
            erase_req     <= ers_d;
            prog_req      <= prg_d;
            dw_req        <= dw_d;
            erase_fail    <= fail_d;
            clear_pulse   <= clr_d;
            suspend_pulse <= sus_d;
            resume_pulse  <= res_d;
            op_addr       <= addr_d;
            op_data       <= data_d;
            op_addr2      <= addr2_d;
            op_data2      <= data2_d;
        end
    end

endmodule

// File: rtl/flash_sig_src.sv
module flash_sig_src #(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] sig_data
);

    localparam int          CW       = 8;
    localparam logic [CW-1:0] MAKER_ID = 8'h20;

    logic [CW-1:0] dev_id;

    generate
        if (TOP_BOOT) begin : g_top
            assign dev_id = 8'h90;
        end else begin : g_bottom
            assign dev_id = 8'h91;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sig_data <= '0;
        else if (rd_addr[0]) sig_data <= {{(DW-CW){1'b0}}, dev_id};
        else                 sig_data <= {{(DW-CW){1'b0}}, MAKER_ID};
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic          busy,
    input  logic          ers_susp,
    input  logic          prg_susp,
    output logic [1:0]    read_mode,
    output logic          erase_req,
    output logic          prog_req,
    output logic          dw_req,
    output logic          erase_fail,
    output logic          clear_pulse,
    output logic          suspend_pulse,
    output logic          resume_pulse,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic [AW-1:0] op_addr2,
    output logic [DW-1:0] op_data2,
    output logic [DW-1:0] sig_data
);

    rd_mode_e mode_q;

    flash_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_stb        (wr_stb),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .busy          (busy),
        .ers_susp      (ers_susp),
        .prg_susp      (prg_susp),
        .mode_q        (mode_q),
        .erase_req     (erase_req),
        .prog_req      (prog_req),
        .dw_req        (dw_req),
        .erase_fail    (erase_fail),
        .clear_pulse   (clear_pulse),
        .suspend_pulse (suspend_pulse),
        .resume_pulse  (resume_pulse),
        .op_addr       (op_addr),
        .op_data       (op_data),
        .op_addr2      (op_addr2),
        .op_data2      (op_data2)
    );

    flash_sig_src #(.AW(AW), .DW(DW), .TOP_BOOT(TOP_BOOT)) u_sig (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (rd_addr),
        .sig_data (sig_data)
    );

    // A running operation forces status reads regardless of the stored mode
    assign read_mode = busy ? RM_STATUS : mode_q;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_stb,
    input logic          busy,
    input logic          ers_susp,
    input logic          prg_susp,
    input logic          erase_req,
    input logic          prog_req,
    input logic          dw_req,
    input logic          erase_fail,
    input logic          clear_pulse,
    input logic          suspend_pulse,
    input logic          resume_pulse,
    input logic [AW-1:0] op_addr,
    input logic [AW-1:0] op_addr2
);

    AST_ONE_PULSE_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_req, prog_req, dw_req, erase_fail, clear_pulse, suspend_pulse, resume_pulse})); // R4

    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req || prog_req || dw_req || erase_fail) |-> $past(wr_stb)); // R4

    AST_BUSY_BLOCKS_CLEAR_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> (!clear_pulse && !resume_pulse)); // R8

    AST_SUSPEND_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_pulse |-> $past(busy)); // R8

    AST_RESUME_NEEDS_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> $past(ers_susp || prg_susp)); // R9

    AST_DW_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        dw_req |-> ((op_addr[AW-1:1] == op_addr2[AW-1:1]) && (op_addr[0] != op_addr2[0]))); // R7

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stb        (wr_stb),
    .busy          (busy),
    .ers_susp      (ers_susp),
    .prg_susp      (prg_susp),
    .erase_req     (erase_req),
    .prog_req      (prog_req),
    .dw_req        (dw_req),
    .erase_fail    (erase_fail),
    .clear_pulse   (clear_pulse),
    .suspend_pulse (suspend_pulse),
    .resume_pulse  (resume_pulse),
    .op_addr       (op_addr),
    .op_addr2      (op_addr2)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [19:0] rd_addr = '0;
    logic        busy = 1'b0;
    logic        ers_susp = 1'b0;
    logic        prg_susp = 1'b0;
    logic [1:0]  read_mode;
    logic        erase_req, prog_req, dw_req, erase_fail;
    logic        clear_pulse, suspend_pulse, resume_pulse;
    logic [19:0] op_addr, op_addr2;
    logic [15:0] op_data, op_data2, sig_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    // pulse snapshot order: erase, prog, dw, fail, clear, suspend, resume
    logic [6:0] pulses;

    always #10 clk = ~clk;

    flash_cmd_decoder #(.AW(20), .DW(16), .TOP_BOOT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .busy(busy), .ers_susp(ers_susp), .prg_susp(prg_susp),
        .read_mode(read_mode), .erase_req(erase_req), .prog_req(prog_req), .dw_req(dw_req),
        .erase_fail(erase_fail), .clear_pulse(clear_pulse), .suspend_pulse(suspend_pulse),
        .resume_pulse(resume_pulse), .op_addr(op_addr), .op_data(op_data),
        .op_addr2(op_addr2), .op_data2(op_data2), .sig_data(sig_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
        pulses  = {erase_req, prog_req, dw_req, erase_fail, clear_pulse, suspend_pulse, resume_pulse};
    endtask

    task automatic t_reset;
        check("R1 mode", {30'd0, read_mode}, 32'd0);
        check("R1 pulses", {25'd0, erase_req, prog_req, dw_req, erase_fail,
                            clear_pulse, suspend_pulse, resume_pulse}, 32'd0);
    endtask

    task automatic t_modes;
        bus_write(20'h0, 16'h0090); check("R2 sig mode", {30'd0, read_mode}, 32'd2);
        bus_write(20'h0, 16'h0098); check("R2 cfi mode", {30'd0, read_mode}, 32'd3);
        bus_write(20'h0, 16'h0070); check("R2 status mode", {30'd0, read_mode}, 32'd1);
        bus_write(20'h0, 16'h00FF); check("R2 array mode", {30'd0, read_mode}, 32'd0);
    endtask

    task automatic t_signature;
        @(negedge clk); rd_addr = 20'h00000;
        @(negedge clk); check("R11 maker code", {16'd0, sig_data}, 32'h0020);
        rd_addr = 20'h00003;
        @(negedge clk); check("R11 device code", {16'd0, sig_data}, 32'h0090);
    endtask

    task automatic t_clear;
        bus_write(20'h0, 16'h0070);
        bus_write(20'h0, 16'h0050);
        check("R3 clear pulse", {25'd0, pulses}, 32'b0000100);
        check("R3 mode kept", {30'd0, read_mode}, 32'd1);
    endtask

    task automatic t_erase;
        bus_write(20'h0, 16'h00FF);
        bus_write(20'h0, 16'h0020);
        bus_write(20'h12345, 16'h00D0);
        check("R4 erase pulse", {25'd0, pulses}, 32'b1000000);
        check("R4 erase addr", {12'd0, op_addr}, 32'h12345);
        check("R4 status mode", {30'd0, read_mode}, 32'd1);
        bus_write(20'h0, 16'h0020);
        bus_write(20'h22222, 16'h0055);
        check("R5 fail pulse", {25'd0, pulses}, 32'b0001000);
        check("R5 array mode", {30'd0, read_mode}, 32'd0);
    endtask

    task automatic t_program;
        bus_write(20'h0, 16'h0040);
        bus_write(20'h0ABCD, 16'hBEEF);
        check("R6 prog pulse 40h", {25'd0, pulses}, 32'b0100000);
        check("R6 prog addr", {12'd0, op_addr}, 32'h0ABCD);
        check("R6 prog data", {16'd0, op_data}, 32'hBEEF);
        check("R6 status mode", {30'd0, read_mode}, 32'd1);
        bus_write(20'h0, 16'h0010);
        bus_write(20'h00042, 16'h1357);
        check("R6 prog pulse 10h", {25'd0, pulses}, 32'b0100000);
        check("R6 prog data 10h", {16'd0, op_data}, 32'h1357);
    endtask

    task automatic t_dword;
        bus_write(20'h0, 16'h00FF);
        bus_write(20'h0, 16'h0030);
        bus_write(20'h00100, 16'h1111);
        check("R7 no start on first word", {25'd0, pulses}, 32'd0);
        bus_write(20'h00101, 16'h2222);
        check("R7 dw pulse", {25'd0, pulses}, 32'b0010000);
        check("R7 addr pair", {op_addr, 12'd0} | {12'd0, op_addr2}, {20'h00100, 12'd0} | 32'h00101);
        check("R7 data pair", {op_data, op_data2}, 32'h11112222);
        check("R7 status mode", {30'd0, read_mode}, 32'd1);
        bus_write(20'h0, 16'h0030);
        bus_write(20'h00100, 16'h3333);
        bus_write(20'h00300, 16'h4444);
        check("R7 bad pair no start", {25'd0, pulses}, 32'd0);
        check("R7 bad pair array", {30'd0, read_mode}, 32'd0);
    endtask

    task automatic t_busy;
        bus_write(20'h0, 16'h00FF);
        @(negedge clk); busy = 1'b1;
        #1 check("R8 busy reads status", {30'd0, read_mode}, 32'd1);
        bus_write(20'h0, 16'h0090);
        check("R8 sig ignored pulse", {25'd0, pulses}, 32'd0);
        bus_write(20'h0, 16'h0040);
        bus_write(20'h00777, 16'h0040);
        check("R8 program ignored", {25'd0, pulses}, 32'd0);
        bus_write(20'h0, 16'h0050);
        check("R8 clear ignored", {25'd0, pulses}, 32'd0);
        bus_write(20'h0, 16'h00B0);
        check("R8 suspend pulse", {25'd0, pulses}, 32'b0000010);
        @(negedge clk); busy = 1'b0;
        #1 check("R8 stored mode untouched", {30'd0, read_mode}, 32'd0);
        @(negedge clk); busy = 1'b1;
        bus_write(20'h0, 16'h0070);
        @(negedge clk); busy = 1'b0;
        #1 check("R8 status accepted", {30'd0, read_mode}, 32'd1);
    endtask

    task automatic t_susp_erase;
        @(negedge clk); ers_susp = 1'b1;
        bus_write(20'h0, 16'h0090);
        check("R9 sig accepted", {30'd0, read_mode}, 32'd2);
        bus_write(20'h0, 16'h0020);
        check("R9 erase setup ignored", {30'd0, read_mode}, 32'd2);
        bus_write(20'h0, 16'h00D0);
        check("R9 confirm after ignored setup is resume", {25'd0, pulses}, 32'b0000001);
        bus_write(20'h0, 16'h0098);
        bus_write(20'h0, 16'h0040);
        bus_write(20'h00200, 16'h5A5A);
        check("R9 program in erase suspend", {25'd0, pulses}, 32'b0100000);
        check("R9 program addr", {12'd0, op_addr}, 32'h00200);
        bus_write(20'h0, 16'h00D0);
        check("R9 resume pulse", {25'd0, pulses}, 32'b0000001);
        check("R9 resume status", {30'd0, read_mode}, 32'd1);
        @(negedge clk); ers_susp = 1'b0;
    endtask

    task automatic t_susp_prog;
        @(negedge clk); prg_susp = 1'b1;
        bus_write(20'h0, 16'h00FF);
        check("R9 array accepted", {30'd0, read_mode}, 32'd0);
        bus_write(20'h0, 16'h0040);
        bus_write(20'h00555, 16'h0098);
        check("R9 program refused in program suspend", {25'd0, pulses}, 32'd0);
        check("R9 next write decoded as command", {30'd0, read_mode}, 32'd3);
        bus_write(20'h0, 16'h00AB);
        check("R9 unknown ignored", {30'd0, read_mode}, 32'd3);
        @(negedge clk); prg_susp = 1'b0;
    endtask

    task automatic t_invalid;
        bus_write(20'h0, 16'h0070);
        bus_write(20'h0, 16'h00AB);
        check("R10 unknown to array", {30'd0, read_mode}, 32'd0);
        bus_write(20'h0, 16'h0070);
        bus_write(20'h0, 16'h00D0);
        check("R10 stray confirm pulse", {25'd0, pulses}, 32'd0);
        check("R10 stray confirm array", {30'd0, read_mode}, 32'd0);
        bus_write(20'h0, 16'h0070);
        bus_write(20'h0, 16'h00B0);
        check("R10 stray suspend pulse", {25'd0, pulses}, 32'd0);
        check("R10 stray suspend array", {30'd0, read_mode}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_modes;
        t_signature;
        t_clear;
        t_erase;
        t_program;
        t_dword;
        t_busy;
        t_susp_erase;
        t_susp_prog;
        t_invalid;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule